// File: doc/BRIEF.md
# Programmable-Timing Asynchronous Peripheral Bus Controller

This controller turns single requests from an internal port into read or write cycles on an external asynchronous peripheral bus. Every cycle is split into three phases: setup, strobe and hold. Reads and writes each have their own set of three lengths, given in clock cycles on static configuration inputs. The controller drives an active-low chip select, a 4-bit word address, an active-low output enable for reads, separate active-low read and write strobes, and a 32-bit data bus with its own drive enable.

An asynchronous active-high ready input can stretch the strobe phase. It passes through a two-stage synchronizer. At one point late in the strobe phase the controller checks the synchronized ready. While that value is low, the strobe is held at that point. Stretching is possible only when setup plus strobe is at least four cycles. For shorter settings the strobe width is fixed and ready has no effect.

On the internal side, a request is a level that the requester holds until the one-cycle acknowledge appears. Read data is returned on the acknowledge. After the hold phase, chip select can remain asserted for a programmable tail of 0 to 7 cycles. No new request is taken before that tail has finished.

Top module: `async_periph_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, bus_cs_n, bus_oe_n, bus_re_n and bus_we_n are 1, and bus_dq_oe and ack are 0.
- R2: A read uses cfg_rd_setup, cfg_rd_strobe and cfg_rd_hold, and a write uses the cfg_wr_* fields. Chip select goes low for the setup count. The strobe is then low for the strobe count (when ready is high). Ack rises once the hold count has elapsed after the strobe rises.
- R3: A phase length of 0 behaves exactly like 1.
- R4: bus_addr equals req_addr and stays stable while chip select is low. For reads, bus_oe_n is low from the start of setup to the end of hold. For writes, bus_dq_oe is 1 and bus_dq_out equals req_wdata over the same span. Both release in the cycle in which ack is high.
- R5: When setup+strobe >= 4 and strobe >= 3, ready is checked at strobe cycle (strobe-3), counting from 0 at the falling strobe. If ready was low before the access and is raised between clock edges ahead of edge A, the strobe rises on the later of two edges: its nominal edge, or edge A+4.
- R6: When setup+strobe < 4, a low ready has no effect and the strobe width equals the programmed count.
- R7: Read data on bus_dq_in is captured at the clock edge where bus_re_n rises. It appears on rdata while ack is high.
- R8: ack is high for exactly one cycle. That cycle is the first one after the hold phase.
- R9: After the cycle in which ack is high, bus_cs_n stays low for a further cfg_cs_tail cycles minus... counted so that bus_cs_n rises exactly cfg_cs_tail cycles after ack.
- R10: A request held high when ack pulses is accepted at the first edge that finds the controller idle with ack low. Between such back-to-back accesses, bus_cs_n is therefore high for 1 cycle if the tail is non-zero and for 2 cycles if the tail is zero.
- R11: During a read bus_we_n stays 1. During a write, bus_re_n and bus_oe_n stay 1. The two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rd_setup | input | 4 | Read setup cycles (0 acts as 1) |
| cfg_rd_strobe | input | 4 | Read strobe cycles |
| cfg_rd_hold | input | 4 | Read hold cycles |
| cfg_wr_setup | input | 4 | Write setup cycles |
| cfg_wr_strobe | input | 4 | Write strobe cycles |
| cfg_wr_hold | input | 4 | Write hold cycles |
| cfg_cs_tail | input | 3 | Extra chip-select cycles after the hold phase |
| req_valid | input | 1 | Request, held until ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word address |
| req_wdata | input | 32 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Captured read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_addr | output | 4 | Word address lines |
| bus_oe_n | output | 1 | Output enable for reads, active low |
| bus_re_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_dq_out | output | 32 | Data driven during writes |
| bus_dq_oe | output | 1 | Drive enable for bus_dq_out |
| bus_dq_in | input | 32 | Data returned by the peripheral |
| bus_rdy | input | 1 | Asynchronous ready, active high |

## Verification
Two events can coincide here. One is the synchronized ready coming back high. The other is the strobe counter arriving at its evaluation point, which decides whether a stall happens at all. A directed sweep moves the instant of the ready rise across that cycle, one cycle per access. Each resulting strobe-rise edge is compared with the later of the nominal edge and four edges after the ready rise. A second coincidence is the acknowledge and a request that is already waiting. Chained accesses present the next request in the ack cycle, and the bench checks the chip-select gap against the tail length.

// File: rtl/apbc_pkg.sv
package apbc_pkg;

    localparam int unsigned CNT_W = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_TAIL
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] strobe;
        logic [CNT_W-1:0] hold;
        logic             ext_en;
        logic [CNT_W-1:0] eval_idx;
    } phase_len_t;

endpackage

// File: rtl/apbc_rdy_sync.sv
module apbc_rdy_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] sh_d;
    logic [STAGES-1:0] sh_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign sh_d[i] = async_i;
        end else begin : g_next
            assign sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sync_o = sh_q[STAGES-1];

endmodule

// File: rtl/apbc_timing.sv
module apbc_timing
    import apbc_pkg::*;
(
    input  logic             is_write,
    input  logic [CNT_W-1:0] rd_setup,
    input  logic [CNT_W-1:0] rd_strobe,
    input  logic [CNT_W-1:0] rd_hold,
    input  logic [CNT_W-1:0] wr_setup,
    input  logic [CNT_W-1:0] wr_strobe,
    input  logic [CNT_W-1:0] wr_hold,
    output phase_len_t       len
);

    localparam logic [CNT_W:0]   EXT_MIN = (CNT_W+1)'(4);
    localparam logic [CNT_W-1:0] EVAL_BACK = CNT_W'(3);

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    // R3: zero lengths behave as one; R5/R6: stretch window and check point
    always_comb begin
        len.setup    = at_least_one(is_write ? wr_setup  : rd_setup);
        len.strobe   = at_least_one(is_write ? wr_strobe : rd_strobe);
        len.hold     = at_least_one(is_write ? wr_hold   : rd_hold);
        len.ext_en   = ({1'b0, len.setup} + {1'b0, len.strobe}) >= EXT_MIN;
        len.eval_idx = (len.strobe >= EVAL_BACK) ? (len.strobe - EVAL_BACK) : '0;
    end

endmodule

// File: rtl/async_periph_ctrl.sv
module async_periph_ctrl
    import apbc_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned TAIL_W      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_rd_setup,
    input  logic [CNT_W-1:0]  cfg_rd_strobe,
    input  logic [CNT_W-1:0]  cfg_rd_hold,
    input  logic [CNT_W-1:0]  cfg_wr_setup,
    input  logic [CNT_W-1:0]  cfg_wr_strobe,
    input  logic [CNT_W-1:0]  cfg_wr_hold,
    input  logic [TAIL_W-1:0] cfg_cs_tail,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_cs_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_oe_n,
    output logic              bus_re_n,
    output logic              bus_we_n,
    output logic [DATA_W-1:0] bus_dq_out,
    output logic              bus_dq_oe,
    input  logic [DATA_W-1:0] bus_dq_in,
    input  logic              bus_rdy
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              ack;
        logic              cs_n;
        logic              oe_n;
        logic              re_n;
        logic              we_n;
        logic              dq_oe;
    } ctl_t;

    ctl_t       cd;
    ctl_t       cq;
    phase_len_t len;
    logic       rdy_s;
    logic       active_d;

    apbc_rdy_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (bus_rdy),
        .sync_o  (rdy_s)
    );

    apbc_timing u_timing (
        .is_write  (cq.wr),
        .rd_setup  (cfg_rd_setup),
        .rd_strobe (cfg_rd_strobe),
        .rd_hold   (cfg_rd_hold),
        .wr_setup  (cfg_wr_setup),
        .wr_strobe (cfg_wr_strobe),
        .wr_hold   (cfg_wr_hold),
        .len       (len)
    );

    always_comb begin
        cd     = cq;
        cd.ack = 1'b0;
        unique case (cq.ph)
            PH_IDLE: begin
                // R10: no acceptance in the ack cycle
                if (req_valid && !cq.ack) begin
                    cd.ph    = PH_SETUP;
                    cd.cnt   = '0;
                    cd.wr    = req_write;
                    cd.addr  = req_addr;
                    cd.wdata = req_wdata;
                end
            end
            PH_SETUP: begin
                if (cq.cnt == len.setup - ONE) begin
                    cd.ph  = PH_STROBE;
                    cd.cnt = '0;
                end else begin
                    cd.cnt = cq.cnt + ONE;
                end
            end
            PH_STROBE: begin
                // R5/R6: stall at the check point while ready is low
                if (len.ext_en && (cq.cnt == len.eval_idx) && !rdy_s) begin
                    cd.cnt = cq.cnt;
                end else if (cq.cnt == len.strobe - ONE) begin
                    cd.ph  = PH_HOLD;
                    cd.cnt = '0;
                    if (!cq.wr) cd.rdata = bus_dq_in;   // R7
                end else begin
                    cd.cnt = cq.cnt + ONE;
                end
            end
            PH_HOLD: begin
                if (cq.cnt == len.hold - ONE) begin
                    cd.ack = 1'b1;
                    cd.cnt = '0;
                    cd.ph  = (cfg_cs_tail == '0) ? PH_IDLE : PH_TAIL;
                end else begin
                    cd.cnt = cq.cnt + ONE;
                end
            end
            PH_TAIL: begin
                if (cq.cnt == CNT_W'(cfg_cs_tail) - ONE) cd.ph = PH_IDLE;
                else                                     cd.cnt = cq.cnt + ONE;
            end
            default: cd.ph = PH_IDLE;
        endcase

        active_d = (cd.ph == PH_SETUP) || (cd.ph == PH_STROBE) || (cd.ph == PH_HOLD);
        cd.cs_n  = (cd.ph == PH_IDLE);
        cd.oe_n  = !(active_d && !cd.wr);
        cd.dq_oe = active_d && cd.wr;
        cd.re_n  = !((cd.ph == PH_STROBE) && !cd.wr);
        cd.we_n  = !((cd.ph == PH_STROBE) && cd.wr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cq       <= '0;
            cq.ph    <= PH_IDLE;
            cq.cs_n  <= 1'b1;
            cq.oe_n  <= 1'b1;
            cq.re_n  <= 1'b1;
            cq.we_n  <= 1'b1;
        end else begin
            cq <= cd;
        end
    end

    assign ack        = cq.ack;
    assign rdata      = cq.rdata;
    assign bus_cs_n   = cq.cs_n;
    assign bus_addr   = cq.addr;
    assign bus_oe_n   = cq.oe_n;
    assign bus_re_n   = cq.re_n;
    assign bus_we_n   = cq.we_n;
    assign bus_dq_out = cq.wdata;
    assign bus_dq_oe  = cq.dq_oe;

    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_re_n && !bus_we_n));

    a_r4_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_re_n || !bus_we_n) |-> !bus_cs_n);

    a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && !$past(bus_cs_n)) |-> $stable(bus_addr));

    a_r4_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_n |-> bus_dq_oe);

endmodule

// File: tb/async_periph_ctrl_bench.sv
`timescale 1ns/1ps
module async_periph_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_rd_setup = '0, cfg_rd_strobe = '0, cfg_rd_hold = '0;
    logic [3:0]  cfg_wr_setup = '0, cfg_wr_strobe = '0, cfg_wr_hold = '0;
    logic [2:0]  cfg_cs_tail = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        ack;
    logic [31:0] rdata;
    logic        bus_cs_n, bus_oe_n, bus_re_n, bus_we_n, bus_dq_oe;
    logic [3:0]  bus_addr;
    logic [31:0] bus_dq_out;
    logic [31:0] bus_dq_in = '0;
    logic        bus_rdy = 1'b1;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int prev_e = -1;
    int prev_c = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    async_periph_ctrl u_async_periph_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_rd_setup(cfg_rd_setup), .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold),
        .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe), .cfg_wr_hold(cfg_wr_hold),
        .cfg_cs_tail(cfg_cs_tail),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .ack(ack), .rdata(rdata),
        .bus_cs_n(bus_cs_n), .bus_addr(bus_addr), .bus_oe_n(bus_oe_n),
        .bus_re_n(bus_re_n), .bus_we_n(bus_we_n),
        .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe), .bus_dq_in(bus_dq_in),
        .bus_rdy(bus_rdy)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int norm(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int exp_rise(input int f, input int tn, input int a, input bit stretch);
        if (stretch && a >= 0 && (a + 4) > (f + tn)) return a + 4;
        return f + tn;
    endfunction

    task automatic do_acc(input bit wr, input logic [3:0] a, input logic [31:0] wd,
                          input int s, input int t, input int h, input int c,
                          input bit rdy_low, input int rdy_dly, input bit chain);
        int sn = norm(s);
        int tn = norm(t);
        int hn = norm(h);
        bit ext = (sn + tn) >= 4;
        logic [31:0] rv = $urandom;
        int tp;
        int c0 = -1, f = -1, r = -1, k = -1, oe = -1, e = -1, ar = -1;
        if (wr) begin
            cfg_wr_setup = 4'(s); cfg_wr_strobe = 4'(t); cfg_wr_hold = 4'(h);
            cfg_rd_setup = 4'($urandom); cfg_rd_strobe = 4'($urandom); cfg_rd_hold = 4'($urandom);
        end else begin
            cfg_rd_setup = 4'(s); cfg_rd_strobe = 4'(t); cfg_rd_hold = 4'(h);
            cfg_wr_setup = 4'($urandom); cfg_wr_strobe = 4'($urandom); cfg_wr_hold = 4'($urandom);
        end
        cfg_cs_tail = 3'(c);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        bus_rdy = !rdy_low;
        bus_dq_in = ~rv;
        tp = cyc;
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            if (rdy_low && ar < 0 && (cyc - tp) == rdy_dly) begin
                bus_rdy = 1'b1;
                ar = cyc + 1;
            end
            if (c0 < 0 && !bus_cs_n) c0 = cyc;
            if (c0 >= 0 && f < 0 && (wr ? !bus_we_n : !bus_re_n)) begin
                f = cyc;
                bus_dq_in = rv;
                chk(bus_addr == a, "R4 address", bus_addr, a);
                if (wr) begin
                    chk(bus_dq_oe == 1'b1, "R4 data drive", bus_dq_oe, 1);
                    chk(bus_dq_out == wd, "R4 write data", bus_dq_out, wd);
                    chk(bus_re_n && bus_oe_n, "R11 read side idle on write", {bus_re_n, bus_oe_n}, 3);
                end else begin
                    chk(bus_oe_n == 1'b0, "R4 output enable", bus_oe_n, 0);
                    chk(bus_dq_oe == 1'b0, "R4 no drive on read", bus_dq_oe, 0);
                    chk(bus_we_n == 1'b1, "R11 write strobe idle on read", bus_we_n, 1);
                end
            end
            if (f >= 0 && r < 0 && (wr ? bus_we_n : bus_re_n)) begin
                r = cyc;
                bus_dq_in = $urandom;
            end
            if (r >= 0 && oe < 0 && (wr ? !bus_dq_oe : bus_oe_n)) oe = cyc;
            if (k < 0 && ack) begin
                k = cyc;
                req_valid = 1'b0;
                if (!wr) chk(rdata == rv, "R7 read data", rdata, rv);
            end
            if (k >= 0 && bus_cs_n) begin
                e = cyc;
                break;
            end
        end
        if (e < 0) begin
            chk(1'b0, "R2 access never completed (watchdog)", cyc, -1);
            req_valid = 1'b0;
        end else begin
            chk(f - c0 == sn, (s == 0) ? "R3 setup length" : "R2 setup length", f - c0, sn);
            if (rdy_low && ext)
                chk(r == exp_rise(f, tn, ar, 1'b1), "R5 stretched strobe rise", r, exp_rise(f, tn, ar, 1'b1));
            else if (rdy_low)
                chk(r - f == tn, "R6 ready ignored, strobe width", r - f, tn);
            else
                chk(r - f == tn, (t == 0) ? "R3 strobe width" : "R2 strobe width", r - f, tn);
            chk(k - r == hn, (h == 0) ? "R3 hold length" : "R8 ack after hold", k - r, hn);
            chk(oe == k, "R4 select release", oe, k);
            chk(e - k == c, "R9 chip-select tail", e - k, c);
            if (chain && prev_e >= 0)
                chk(c0 == prev_e + ((prev_c == 0) ? 2 : 1), "R10 back-to-back gap",
                    c0 - prev_e, (prev_c == 0) ? 2 : 1);
            prev_e = e;
            prev_c = c;
        end
    endtask

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'd9173);
        repeat (5) @(negedge clk);
        chk(bus_cs_n && bus_oe_n && bus_re_n && bus_we_n, "R1 strobes idle in reset",
            {bus_cs_n, bus_oe_n, bus_re_n, bus_we_n}, 15);
        chk(!bus_dq_oe && !ack, "R1 drive and ack low in reset", {bus_dq_oe, ack}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_cs_n && bus_oe_n && bus_re_n && bus_we_n && !bus_dq_oe && !ack,
            "R1 idle after reset", {bus_cs_n, bus_oe_n, bus_re_n, bus_we_n, bus_dq_oe, ack}, 60);

        // directed corners
        do_acc(1'b0, 4'h3, 32'h0, 2, 3, 2, 0, 1'b0, 0, 1'b0);
        do_acc(1'b1, 4'hA, 32'hCAFE_0001, 2, 3, 2, 3, 1'b0, 0, 1'b1);
        do_acc(1'b0, 4'h1, 32'h0, 0, 0, 0, 0, 1'b0, 0, 1'b1);            // R3 all zero
        do_acc(1'b1, 4'h2, 32'h1234_5678, 0, 0, 0, 1, 1'b0, 0, 1'b1);    // R3
        do_acc(1'b0, 4'h4, 32'h0, 1, 1, 1, 0, 1'b1, 30, 1'b1);           // R6 sum 2
        do_acc(1'b1, 4'h5, 32'h0BAD_F00D, 2, 1, 1, 0, 1'b1, 30, 1'b1);   // R6 sum 3
        do_acc(1'b0, 4'h6, 32'h0, 1, 3, 2, 7, 1'b1, 15, 1'b1);           // R5 stall, R9 tail 7
        do_acc(1'b1, 4'h7, 32'h5A5A_A5A5, 3, 15, 1, 2, 1'b1, 8, 1'b1);   // R5 early release
        // R5 sweep of the ready rise across the check point
        for (int d = 1; d <= 12; d++)
            do_acc(d[0], 4'(d), 32'(d * 32'h0101_0101), 2, 4, 1, d % 3, 1'b1, d, 1'b1);

        // constrained random
        for (int i = 0; i < 70; i++) begin
            bit wr  = 1'($urandom % 2);
            int s   = int'($urandom % 7);
            int t   = int'($urandom % 8);
            int h   = int'($urandom % 6);
            int c   = int'($urandom % 8);
            bit rl  = ($urandom % 3) == 0;
            int dly = 1 + int'($urandom % 25);
            bit ch  = ($urandom % 4) != 0;
            if (rl && (norm(s) + norm(t)) >= 4 && norm(t) < 3) t = 3;
            if (!ch) repeat (1 + ($urandom % 3)) @(negedge clk);
            do_acc(wr, 4'($urandom), $urandom, s, t, h, c, rl, dly, ch);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule